// File: doc/BRIEF.md
# Calendar Next-Day Register

This block keeps a calendar date made of three fields: the month, the day within the month, and the day of the week. The fields sit in clocked registers. A pulse on the advance input moves the date forward by one day. Combinational logic works out tomorrow's date from today's. It knows the length of each month, carries into the next month, wraps December back to January and cycles the weekday through seven values. There is no year count and no leap-year rule, so February always has 28 days.

A host can overwrite all three fields at once through the load port. If a load and an advance arrive in the same cycle, the load wins. A Sunday flag is derived from the weekday field, and downstream logic can use it directly. When neither load nor advance is asserted, the date holds.

Top module: `cal_day_reg`

## Requirements
- R1: While rst_n is low, and after it is released, the date reads month 1, day 1, weekday 0 until the first load or advance.
- R2: When day_o is at or above the month length, an advance sets day_o to 1 and adds one to month_o. The length is 28 for month code 2, 30 for codes 4, 6, 9 and 11, and 31 for every other code.
- R3: When day_o is below the month length, an advance adds one to day_o and leaves month_o unchanged.
- R4: An advance from month 12 with the day at or above 31 gives month 1, day 1.
- R5: Every advance adds one to dow_o, except that weekday 6 (or any code of 6 and above) goes to 0.
- R6: sunday_o is 1 exactly when dow_o is 0, where 0 means Sunday.
- R7: When load_i is high at a clock edge, the load fields appear on the outputs after that edge. This is true whatever adv_i is doing.
- R8: If neither load_i nor adv_i is high at an edge, the three fields keep their values across that edge.
- R9: The illegal month codes 0, 13, 14 and 15 use a length of 31. Rolling over from any code of 12 or above gives month 1, and rolling over from code 0 gives month 1.
- R10: Starting from January 1, 365 advances return the date to January 1, with the weekday moved forward by one, modulo 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Write the load fields into the date |
| load_month_i | input | 4 | Month to load, 1 = January .. 12 = December |
| load_day_i | input | 5 | Day of month to load, counted from 1 |
| load_dow_i | input | 3 | Weekday to load, 0 = Sunday .. 6 = Saturday |
| adv_i | input | 1 | Advance to the next day |
| month_o | output | 4 | Current month |
| day_o | output | 5 | Current day of month |
| dow_o | output | 3 | Current weekday |
| sunday_o | output | 1 | High when the current weekday is Sunday |

## Verification
The bench first loads the last day of a 28-day, a 30-day and a 31-day month, and also a mid-month day. Each advance must then either wrap the day or only count it up, which shows whether the right month length was chosen. A full year walked from January 1 is compared day by day against a model kept in the bench. This run covers every month boundary, the December wrap and the weekday drift of one.

Further cases load and advance in the same cycle, which must give the loaded value, and idle the block, which must hold the date. Loaded illegal month codes show that the default length and the rollover to January apply. Weekday loads of 6 and 0 exercise the week wrap and the Sunday flag.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int MON_W     = 4;
  localparam int DOM_W     = 5;
  localparam int DOW_W     = 3;
  localparam int YEAR_MON  = 12;
  localparam int WEEK_DAYS = 7;
  localparam int LAST_DOW  = WEEK_DAYS - 1;

  typedef struct packed {
    logic [MON_W-1:0] month;
    logic [DOM_W-1:0] day;
    logic [DOW_W-1:0] dow;
  } cal_date_t;

  localparam cal_date_t CAL_RESET = '{month: MON_W'(1), day: DOM_W'(1), dow: DOW_W'(0)};
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [MON_W-1:0] month_i,
  output logic [DOM_W-1:0] len_o
);
  always_comb begin
    case (month_i)
      MON_W'(2):                                   len_o = DOM_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): len_o = DOM_W'(30);
      default:                                     len_o = DOM_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_next_day.sv
module cal_next_day
  import cal_pkg::*;
(
  input  cal_date_t today_i,
  output cal_date_t tomorrow_o
);
  logic [DOM_W-1:0] month_len;
  logic             month_end;

  cal_month_len u_len (
    .month_i (today_i.month),
    .len_o   (month_len)
  );

  assign month_end = (today_i.day >= month_len);

  always_comb begin
    tomorrow_o = today_i;
    if (month_end) begin
      tomorrow_o.day = DOM_W'(1);
      if (today_i.month >= MON_W'(YEAR_MON)) tomorrow_o.month = MON_W'(1);
      else                                   tomorrow_o.month = today_i.month + MON_W'(1);
    end else begin
      tomorrow_o.day = today_i.day + DOM_W'(1);
    end
    if (today_i.dow >= DOW_W'(LAST_DOW)) tomorrow_o.dow = DOW_W'(0);
    else                                 tomorrow_o.dow = today_i.dow + DOW_W'(1);
  end
endmodule

// File: rtl/cal_state_reg.sv
module cal_state_reg
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  cal_date_t load_val_i,
  input  logic      adv_i,
  input  cal_date_t next_val_i,
  output cal_date_t date_o
);
  cal_date_t date_q;
  cal_date_t date_d;
  logic      date_en;

  always_comb begin
    date_en = load_i | adv_i;
    if (load_i) date_d = load_val_i;
    else        date_d = next_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       date_q <= CAL_RESET;
    else if (date_en) date_q <= date_d;
  end

  assign date_o = date_q;
endmodule

// File: rtl/cal_day_reg.sv
module cal_day_reg
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [MON_W-1:0] load_month_i,
  input  logic [DOM_W-1:0] load_day_i,
  input  logic [DOW_W-1:0] load_dow_i,
  input  logic             adv_i,
  output logic [MON_W-1:0] month_o,
  output logic [DOM_W-1:0] day_o,
  output logic [DOW_W-1:0] dow_o,
  output logic             sunday_o
);
  cal_date_t today;
  cal_date_t tomorrow;
  cal_date_t load_val;

  assign load_val = '{month: load_month_i, day: load_day_i, dow: load_dow_i};

  cal_next_day u_next (
    .today_i    (today),
    .tomorrow_o (tomorrow)
  );

  cal_state_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_val),
    .adv_i      (adv_i),
    .next_val_i (tomorrow),
    .date_o     (today)
  );

  assign month_o  = today.month;
  assign day_o    = today.day;
  assign dow_o    = today.dow;
  assign sunday_o = (today.dow == DOW_W'(0));
endmodule

// File: rtl/cal_day_reg_chk.sv
module cal_day_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic [3:0] load_month_i,
  input logic [4:0] load_day_i,
  input logic [2:0] load_dow_i,
  input logic       adv_i,
  input logic [3:0] month_o,
  input logic [4:0] day_o,
  input logic [2:0] dow_o,
  input logic       sunday_o
);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(month_o) && $stable(day_o) && $stable(dow_o)));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (month_o == $past(load_month_i) && day_o == $past(load_day_i)
                && dow_o == $past(load_dow_i)));

  // R3
  mid_month_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && day_o < 5'd28) |=> (day_o == $past(day_o) + 5'd1 && $stable(month_o)));

  // R4
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && month_o == 4'd12 && day_o >= 5'd31) |=> (month_o == 4'd1 && day_o == 5'd1));

  // R5
  week_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && dow_o == 3'd6) |=> (dow_o == 3'd0));

  // R6
  sunday_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sunday_o) && !$past(load_i)) |-> ($past(dow_o) == 3'd6 && $past(adv_i)));
endmodule

bind cal_day_reg cal_day_reg_chk u_chk (.*);

// File: tb/sim_cal_day_reg.sv
`timescale 1ns/1ps
module sim_cal_day_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [3:0] load_month_i;
  logic [4:0] load_day_i;
  logic [2:0] load_dow_i;
  logic       adv_i;
  logic [3:0] month_o;
  logic [4:0] day_o;
  logic [2:0] dow_o;
  logic       sunday_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cal_day_reg u0 (.*);

  function automatic logic [4:0] ref_len(input logic [3:0] m);
    if (m == 4'd2) return 5'd28;
    if (m == 4'd4 || m == 4'd6 || m == 4'd9 || m == 4'd11) return 5'd30;
    return 5'd31;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic l, input logic [3:0] m,
                     input logic [4:0] d, input logic [2:0] w);
    @(negedge clk);
    adv_i = a; load_i = l; load_month_i = m; load_day_i = d; load_dow_i = w;
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [3:0] m, input logic [4:0] d, input logic [2:0] w);
    cyc(1'b0, 1'b1, m, d, w);
  endtask

  task automatic step();
    cyc(1'b1, 1'b0, 4'd0, 5'd0, 3'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; adv_i = 1'b0; load_i = 1'b0;
    load_month_i = 4'd0; load_day_i = 5'd0; load_dow_i = 3'd0;
    #1;
    chk("R1 during reset", {month_o, day_o, dow_o}, {4'd1, 5'd1, 3'd0});
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", {month_o, day_o, dow_o}, {4'd1, 5'd1, 3'd0});
    chk("R6 sunday at reset", {11'd0, sunday_o}, 12'd1);
  endtask

  task automatic t_hold();
    put(4'd7, 5'd14, 3'd3);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 4'd9, 5'd9, 3'd1);
    chk("R8 idle hold", {month_o, day_o, dow_o}, {4'd7, 5'd14, 3'd3});
  endtask

  task automatic t_load_priority();
    put(4'd3, 5'd31, 3'd2);
    chk("R7 plain load", {month_o, day_o, dow_o}, {4'd3, 5'd31, 3'd2});
    cyc(1'b1, 1'b1, 4'd10, 5'd5, 3'd4);
    chk("R7 load beats advance", {month_o, day_o, dow_o}, {4'd10, 5'd5, 3'd4});
  endtask

  task automatic t_month_ends();
    put(4'd2, 5'd28, 3'd1); step();
    chk("R2 February end", {month_o, day_o}, {4'd3, 5'd1, 3'd0} >> 3);
    put(4'd2, 5'd27, 3'd1); step();
    chk("R3 February 27", {month_o, day_o}, {4'd2, 5'd28, 3'd0} >> 3);
    put(4'd9, 5'd30, 3'd1); step();
    chk("R2 30-day end", {month_o, day_o}, {4'd10, 5'd1, 3'd0} >> 3);
    put(4'd8, 5'd30, 3'd1); step();
    chk("R3 31-day month day 30", {month_o, day_o}, {4'd8, 5'd31, 3'd0} >> 3);
    put(4'd8, 5'd31, 3'd1); step();
    chk("R2 31-day end", {month_o, day_o}, {4'd9, 5'd1, 3'd0} >> 3);
  endtask

  task automatic t_dec_roll();
    put(4'd12, 5'd31, 3'd4); step();
    chk("R4 year wrap", {month_o, day_o, dow_o}, {4'd1, 5'd1, 3'd5});
  endtask

  task automatic t_week();
    put(4'd5, 5'd10, 3'd6);
    chk("R6 not sunday", {11'd0, sunday_o}, 12'd0);
    step();
    chk("R5 week wrap", {9'd0, dow_o}, 12'd0);
    chk("R6 sunday after wrap", {11'd0, sunday_o}, 12'd1);
    step();
    chk("R5 weekday count", {9'd0, dow_o}, 12'd1);
    chk("R6 sunday cleared", {11'd0, sunday_o}, 12'd0);
  endtask

  task automatic t_illegal();
    put(4'd13, 5'd30, 3'd0); step();
    chk("R9 code 13 has 31 days", {month_o, day_o}, {4'd13, 5'd31, 3'd0} >> 3);
    step();
    chk("R9 code 13 rolls to 1", {month_o, day_o}, {4'd1, 5'd1, 3'd0} >> 3);
    put(4'd0, 5'd31, 3'd0); step();
    chk("R9 code 0 rolls to 1", {month_o, day_o}, {4'd1, 5'd1, 3'd0} >> 3);
  endtask

  task automatic t_year();
    logic [3:0] m = 4'd1;
    logic [4:0] d = 5'd1;
    logic [2:0] w = 3'd3;
    int bad = 0;
    put(m, d, w);
    for (int i = 0; i < 365; i++) begin
      if (d >= ref_len(m)) begin d = 5'd1; m = (m >= 4'd12) ? 4'd1 : m + 4'd1; end
      else d = d + 5'd1;
      w = (w >= 3'd6) ? 3'd0 : w + 3'd1;
      step();
      if ({month_o, day_o, dow_o} !== {m, d, w}) begin
        bad++;
        if (bad <= 3) chk("R2 R3 year walk", {month_o, day_o, dow_o}, {m, d, w});
      end
    end
    chk("R10 year returns", {month_o, day_o, dow_o}, {4'd1, 5'd1, 3'd4});
  endtask

  initial begin
    t_reset();
    t_hold();
    t_load_priority();
    t_month_ends();
    t_dec_roll();
    t_week();
    t_illegal();
    t_year();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule